// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block executes one string operation, or a counted repetition of it, over a byte-wide memory port with a request/acknowledge handshake. On `start`, it captures start values for the source index, the destination index, the count, the two segment bases, the direction flag, the accumulator and a 6-bit opcode. It then steps through the elements one byte access at a time. For each element it forms 20-bit physical addresses, reads or writes the bytes, and updates the index registers, the count, the zero flag and the accumulator.

The opcode selects one of five operations: copy, compare, scan, load or store. It also selects a byte or word element size and a repeat mode: single, counted, repeat-while-equal or repeat-while-unequal. The block raises `done` for one cycle when the operation or repetition finishes. The final register values then stay on the outputs until the next `start`.

The state machine has eight states. `IDLE` waits for `start` and loads the operands, then moves to `CHECK`. `CHECK` moves to `FINISH` if a repeat mode is active and the count is zero. Otherwise it moves to the first access state of the element. `SRC_LO` and `SRC_HI` read the source bytes. `DST_LO` and `DST_HI` read or write the destination bytes. Each access state leaves only on `mem_ack`. `SRC_LO` goes to `SRC_HI` for word elements. Otherwise it goes to `DST_LO`, or to `UPDATE` when the operation is a load. `SRC_HI` goes to `DST_LO`, or to `UPDATE` for a load. `DST_LO` goes to `DST_HI` for word elements, otherwise to `UPDATE`. `DST_HI` always goes to `UPDATE`. `UPDATE` steps the indices and the count, then goes back to `CHECK` to repeat or on to `FINISH`. `FINISH` pulses `done` and returns to `IDLE`.

Top module: `strx_engine`

## Requirements
- R1: Each byte address is `{segment, 4'h0} + offset`, taken modulo 2^20. The offset arithmetic wraps modulo 2^16 and never carries into the segment. The high byte of a word element sits at offset+1, also wrapped.
- R2: `opcode[2:0]` selects the operation: 0 copy, 1 compare, 2 scan, 3 load, 4 store. `opcode[3]` set means word elements. `opcode[5:4]` selects the repeat mode: 0 single, 1 counted, 2 while-equal, 3 while-unequal. A copy writes the element read at the source address (DS, SI) to the destination address (ES, DI).
- R3: A compare tests the source element minus the destination element. A scan tests AL (or AX for words) minus the destination element. In both cases ZF becomes 1 exactly when the result is zero. No other operation changes ZF.
- R4: After each element, each index the operation uses moves by +1 (byte) or +2 (word) when the direction flag is 0, and by -1 or -2 when it is 1. Copy and compare move both indices. Scan and store move only DI. Load moves only SI.
- R5: A load places the source byte in AL, leaving AH unchanged, or the source word in AX. A store writes AL to ES:DI and, for words, AH to ES:DI+1.
- R6: With a repeat mode active, CX decreases by one after each element, and the repetition ends when CX reaches zero. In single mode exactly one element is processed and CX is unchanged.
- R7: For compare and scan, the while-equal mode also ends after the first unequal element, and the while-unequal mode ends after the first equal one. In both cases CX and the indices are stepped before the stop. For copy, load and store these two modes count exactly like the counted mode.
- R8: If a repeat mode is active and CX is zero at start, no memory access is made, every register keeps its start value, and `done` follows.
- R9: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_ack` is sampled high. Each acknowledge completes exactly one byte access.
- R10: `busy` is high from the cycle after an accepted `start` through the single cycle in which `done` is high. A `start` that arrives while `busy` is high is ignored.
- R11: After reset the index, count, accumulator and flag outputs are zero, and `busy`, `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch the operation (accepted only when idle) |
| opcode | input | 6 | Operation, element size and repeat mode |
| si_init | input | 16 | Start value of the source index |
| di_init | input | 16 | Start value of the destination index |
| cx_init | input | 16 | Start value of the count |
| ds_init | input | 16 | Source segment base |
| es_init | input | 16 | Destination segment base |
| df_init | input | 1 | Direction flag, 1 steps downward |
| ax_init | input | 16 | Start value of the accumulator |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 20 | Physical byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Access completed this cycle |
| mem_rdata | input | 8 | Read byte, valid with `mem_ack` |
| si | output | 16 | Source index |
| di | output | 16 | Destination index |
| cx | output | 16 | Count |
| ax | output | 16 | Accumulator |
| zf | output | 1 | Zero flag from the last compare or scan |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |

## Verification
In the `UPDATE` cycle, the compare verdict and the count reaching zero can both land at once. Which of them ends the repetition then decides whether ZF, CX and the indices show a stop on a match or a stop on exhaustion. Directed cases provoke this by placing the terminating equal, or unequal, element exactly at the last counted position, in both byte and word size. Random cases draw operand bytes from a narrow value range so that matches occur often. The final CX, ZF and indices are then compared with a bench model that steps through the elements from the requirements.

// File: rtl/strx_pkg.sv
package strx_pkg;

    typedef enum logic [2:0] {
        K_MOVE  = 3'd0,
        K_CMP   = 3'd1,
        K_SCAN  = 3'd2,
        K_LOAD  = 3'd3,
        K_STORE = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        P_NONE  = 2'd0,
        P_REP   = 2'd1,
        P_REPE  = 2'd2,
        P_REPNE = 2'd3
    } pfx_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_SRC_LO,
        S_SRC_HI,
        S_DST_LO,
        S_DST_HI,
        S_UPDATE,
        S_FINISH
    } state_e;

    function automatic kind_e decode_kind(input logic [2:0] code);
        kind_e k;
        unique case (code)
            3'd1:    k = K_CMP;
            3'd2:    k = K_SCAN;
            3'd3:    k = K_LOAD;
            3'd4:    k = K_STORE;
            default: k = K_MOVE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/strx_phys_addr.sv
module strx_phys_addr #(
    parameter int SEG_W     = 16,
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    localparam int ADDR_W   = SEG_W + SEG_SHIFT
) (
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic              hi_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [OFF_W-1:0] off_eff;

    always_comb begin
        off_eff = off_i + OFF_W'(hi_i);
        addr_o  = {seg_i, {SEG_SHIFT{1'b0}}} + ADDR_W'(off_eff);
    end
endmodule

// File: rtl/strx_ptr_step.sv
module strx_ptr_step #(
    parameter int OFF_W = 16
) (
    input  logic [OFF_W-1:0] ptr_i,
    input  logic             word_i,
    input  logic             down_i,
    output logic [OFF_W-1:0] ptr_o
);
    logic [OFF_W-1:0] delta;

    always_comb begin
        delta = word_i ? OFF_W'(2) : OFF_W'(1);
        ptr_o = down_i ? (ptr_i - delta) : (ptr_i + delta);
    end
endmodule

// File: rtl/strx_elem_cmp.sv
module strx_elem_cmp #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic [WORD_W-1:0] lhs_i,
    input  logic [WORD_W-1:0] rhs_i,
    input  logic              word_i,
    output logic              equal_o
);
    logic [WORD_W-1:0] diff;

    always_comb begin
        diff    = lhs_i - rhs_i;
        equal_o = word_i ? (diff == '0) : (diff[BYTE_W-1:0] == '0);
    end
endmodule

// File: rtl/strx_engine.sv
module strx_engine
    import strx_pkg::*;
#(
    parameter int SEG_W     = 16,
    parameter int OFF_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int BYTE_W    = 8,
    localparam int ADDR_W   = SEG_W + SEG_SHIFT,
    localparam int WORD_W   = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [5:0]        opcode,
    input  logic [OFF_W-1:0]  si_init,
    input  logic [OFF_W-1:0]  di_init,
    input  logic [OFF_W-1:0]  cx_init,
    input  logic [SEG_W-1:0]  ds_init,
    input  logic [SEG_W-1:0]  es_init,
    input  logic              df_init,
    input  logic [WORD_W-1:0] ax_init,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [OFF_W-1:0]  si,
    output logic [OFF_W-1:0]  di,
    output logic [OFF_W-1:0]  cx,
    output logic [WORD_W-1:0] ax,
    output logic              zf,
    output logic              busy,
    output logic              done
);
    localparam int N_PTR = 2;

    state_e            st_q, st_d;
    kind_e             kind_q;
    pfx_e              pfx_q;
    logic              word_q, df_q;
    logic [OFF_W-1:0]  si_q, di_q, cx_q;
    logic [SEG_W-1:0]  ds_q, es_q;
    logic [WORD_W-1:0] ax_q, src_q, dst_q;
    logic              zf_q;

    logic              uses_src, uses_dst, is_cmp, dst_write, has_pfx;
    logic              elem_eq, again;
    logic [OFF_W-1:0]  cx_dec;
    state_e            first_st;

    logic [SEG_W-1:0]  acc_seg;
    logic [OFF_W-1:0]  acc_off;
    logic              acc_hi;
    logic [WORD_W-1:0] wr_src, cmp_lhs;

    logic [OFF_W-1:0]  ptr_cur [N_PTR];
    logic [OFF_W-1:0]  ptr_nxt [N_PTR];

    // operation roles
    always_comb begin
        uses_src  = (kind_q == K_MOVE) || (kind_q == K_CMP) || (kind_q == K_LOAD);
        uses_dst  = (kind_q != K_LOAD);
        is_cmp    = (kind_q == K_CMP) || (kind_q == K_SCAN);
        dst_write = (kind_q == K_MOVE) || (kind_q == K_STORE);
        has_pfx   = (pfx_q != P_NONE);
        first_st  = uses_src ? S_SRC_LO : S_DST_LO;
        cx_dec    = cx_q - OFF_W'(1);
        wr_src    = (kind_q == K_MOVE) ? src_q : ax_q;
        cmp_lhs   = (kind_q == K_SCAN) ? ax_q : src_q;
    end

    // repeat decision
    always_comb begin
        again = 1'b0;
        if (has_pfx && (cx_dec != '0)) begin
            if (!is_cmp) begin
                again = 1'b1;
            end else begin
                unique case (pfx_q)
                    P_REPE:  again = elem_eq;
                    P_REPNE: again = !elem_eq;
                    default: again = 1'b1;
                endcase
            end
        end
    end

    strx_elem_cmp #(.BYTE_W(BYTE_W)) u_cmp (
        .lhs_i  (cmp_lhs),
        .rhs_i  (dst_q),
        .word_i (word_q),
        .equal_o(elem_eq)
    );

    assign ptr_cur[0] = si_q;
    assign ptr_cur[1] = di_q;

    for (genvar g = 0; g < N_PTR; g++) begin : g_step
        strx_ptr_step #(.OFF_W(OFF_W)) u_step (
            .ptr_i (ptr_cur[g]),
            .word_i(word_q),
            .down_i(df_q),
            .ptr_o (ptr_nxt[g])
        );
    end

    // address source select
    always_comb begin
        if ((st_q == S_SRC_LO) || (st_q == S_SRC_HI)) begin
            acc_seg = ds_q;
            acc_off = si_q;
        end else begin
            acc_seg = es_q;
            acc_off = di_q;
        end
        acc_hi = (st_q == S_SRC_HI) || (st_q == S_DST_HI);
    end

    strx_phys_addr #(.SEG_W(SEG_W), .OFF_W(OFF_W), .SEG_SHIFT(SEG_SHIFT)) u_addr (
        .seg_i (acc_seg),
        .off_i (acc_off),
        .hi_i  (acc_hi),
        .addr_o(mem_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (start) st_d = S_CHECK;
            S_CHECK:  st_d = (has_pfx && (cx_q == '0)) ? S_FINISH : first_st;
            S_SRC_LO: if (mem_ack)
                          st_d = word_q ? S_SRC_HI
                                        : ((kind_q == K_LOAD) ? S_UPDATE : S_DST_LO);
            S_SRC_HI: if (mem_ack) st_d = (kind_q == K_LOAD) ? S_UPDATE : S_DST_LO;
            S_DST_LO: if (mem_ack) st_d = word_q ? S_DST_HI : S_UPDATE;
            S_DST_HI: if (mem_ack) st_d = S_UPDATE;
            S_UPDATE: st_d = again ? S_CHECK : S_FINISH;
            S_FINISH: st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_wdata = wr_src[BYTE_W-1:0];
        unique case (st_q)
            S_SRC_LO, S_SRC_HI: mem_req = 1'b1;
            S_DST_LO: begin
                mem_req = 1'b1;
                mem_we  = dst_write;
            end
            S_DST_HI: begin
                mem_req   = 1'b1;
                mem_we    = dst_write;
                mem_wdata = wr_src[WORD_W-1:BYTE_W];
            end
            default: ;
        endcase
        busy = (st_q != S_IDLE);
        done = (st_q == S_FINISH);
        si   = si_q;
        di   = di_q;
        cx   = cx_q;
        ax   = ax_q;
        zf   = zf_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q <= K_MOVE;
            pfx_q  <= P_NONE;
            word_q <= 1'b0;
            df_q   <= 1'b0;
            si_q   <= '0;
            di_q   <= '0;
            cx_q   <= '0;
            ds_q   <= '0;
            es_q   <= '0;
            ax_q   <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            zf_q   <= 1'b0;
        end else begin
            unique case (st_q)
                S_IDLE: if (start) begin
                    kind_q <= decode_kind(opcode[2:0]);
                    word_q <= opcode[3];
                    pfx_q  <= pfx_e'(opcode[5:4]);
                    df_q   <= df_init;
                    si_q   <= si_init;
                    di_q   <= di_init;
                    cx_q   <= cx_init;
                    ds_q   <= ds_init;
                    es_q   <= es_init;
                    ax_q   <= ax_init;
                end
                S_SRC_LO: if (mem_ack) src_q[BYTE_W-1:0] <= mem_rdata;
                S_SRC_HI: if (mem_ack) src_q[WORD_W-1:BYTE_W] <= mem_rdata;
                S_DST_LO: if (mem_ack && !dst_write) dst_q[BYTE_W-1:0] <= mem_rdata;
                S_DST_HI: if (mem_ack && !dst_write) dst_q[WORD_W-1:BYTE_W] <= mem_rdata;
                S_UPDATE: begin
                    if (uses_src) si_q <= ptr_nxt[0];
                    if (uses_dst) di_q <= ptr_nxt[1];
                    if (has_pfx)  cx_q <= cx_dec;
                    if (is_cmp)   zf_q <= elem_eq;
                    if (kind_q == K_LOAD) begin
                        if (word_q) ax_q <= src_q;
                        else        ax_q[BYTE_W-1:0] <= src_q[BYTE_W-1:0];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/strx_engine_chk.sv
module strx_engine_chk #(
    parameter int OFF_W  = 16,
    parameter int ADDR_W = 20,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [BYTE_W-1:0] mem_wdata,
    input logic              mem_ack,
    input logic [OFF_W-1:0]  si,
    input logic [OFF_W-1:0]  di,
    input logic [OFF_W-1:0]  cx,
    input logic              busy,
    input logic              done
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata))); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy)); // R10

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_req && !done)); // R10

    AST_CX_DOWN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (cx != $past(cx))) |-> (cx == $past(cx) - OFF_W'(1))); // R6

    AST_SI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (si != $past(si))) |->
        ((si == $past(si) + OFF_W'(1)) || (si == $past(si) + OFF_W'(2)) ||
         (si == $past(si) - OFF_W'(1)) || (si == $past(si) - OFF_W'(2)))); // R4

    AST_DI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (di != $past(di))) |->
        ((di == $past(di) + OFF_W'(1)) || (di == $past(di) + OFF_W'(2)) ||
         (di == $past(di) - OFF_W'(1)) || (di == $past(di) - OFF_W'(2)))); // R4
endmodule

bind strx_engine strx_engine_chk #(.OFF_W(OFF_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_ack  (mem_ack),
    .si       (si),
    .di       (di),
    .cx       (cx),
    .busy     (busy),
    .done     (done)
);

// File: tb/sim_strx_engine.sv
module sim_strx_engine;
    localparam logic [2:0] OP_MOVE = 3'd0, OP_CMP = 3'd1, OP_SCAN = 3'd2,
                           OP_LOAD = 3'd3, OP_STORE = 3'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  opcode = '0;
    logic [15:0] si_init = '0, di_init = '0, cx_init = '0, ds_init = '0, es_init = '0, ax_init = '0;
    logic        df_init = 1'b0;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata = '0;
    logic [15:0] si, di, cx, ax;
    logic        zf, busy, done;

    int n_chk = 0, n_fail = 0, n_acks = 0, r_acc = 0;
    logic [1:0] wcnt = '0;
    logic [7:0] mem  [int];
    logic [7:0] rmem [int];
    logic [15:0] e_si, e_di, e_cx, e_ds, e_es, e_ax;
    logic        e_df, e_zf = 1'b0;

    always #2.5 clk = ~clk;

    strx_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .si_init(si_init), .di_init(di_init), .cx_init(cx_init),
        .ds_init(ds_init), .es_init(es_init), .df_init(df_init), .ax_init(ax_init),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .si(si), .di(di), .cx(cx), .ax(ax), .zf(zf), .busy(busy), .done(done)
    );

    // memory responder with random wait states
    always @(negedge clk) begin
        if (!rst_n || !mem_req) begin
            mem_ack <= 1'b0;
            wcnt    <= 2'($urandom_range(0, 2));
        end else if (wcnt == 2'd0) begin
            mem_ack <= 1'b1;
            n_acks  <= n_acks + 1;
            if (mem_we) mem[int'(mem_addr)] = mem_wdata;
            else        mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
            wcnt    <= 2'($urandom_range(0, 2));
        end else begin
            mem_ack <= 1'b0;
            wcnt    <= wcnt - 2'd1;
        end
    end

    function automatic int phys(input logic [15:0] seg, input logic [15:0] off);
        logic [19:0] p;
        p = {seg, 4'h0} + {4'h0, off};
        return int'(p);
    endfunction

    function automatic logic [7:0] rdm(input int a);
        return rmem.exists(a) ? rmem[a] : 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [7:0] v);
        mem[a]  = v;
        rmem[a] = v;
    endtask

    task automatic fill(input logic [15:0] seg, input logic [15:0] off, input int maxv);
        for (int k = -16; k <= 16; k++)
            put(phys(seg, off + 16'(k)), 8'($urandom_range(0, maxv)));
    endtask

    // reference: steps elements as the requirements describe
    task automatic ref_exec(input logic [5:0] opc);
        logic [2:0]  kd;
        logic        wd;
        logic [1:0]  pf;
        logic [15:0] s, d, lhs, stp;
        kd  = opc[2:0];
        wd  = opc[3];
        pf  = opc[5:4];
        stp = wd ? 16'd2 : 16'd1;
        if (e_df) stp = -stp;
        if (pf != 2'd0 && e_cx == 16'd0) return;
        forever begin
            s = '0;
            d = '0;
            if (kd == OP_MOVE || kd == OP_CMP || kd == OP_LOAD) begin
                s[7:0] = rdm(phys(e_ds, e_si));
                if (wd) s[15:8] = rdm(phys(e_ds, e_si + 16'd1));
                r_acc += wd ? 2 : 1;
            end
            if (kd == OP_CMP || kd == OP_SCAN) begin
                d[7:0] = rdm(phys(e_es, e_di));
                if (wd) d[15:8] = rdm(phys(e_es, e_di + 16'd1));
                r_acc += wd ? 2 : 1;
            end
            if (kd == OP_MOVE || kd == OP_STORE) begin
                lhs = (kd == OP_MOVE) ? s : e_ax;
                rmem[phys(e_es, e_di)] = lhs[7:0];
                if (wd) rmem[phys(e_es, e_di + 16'd1)] = lhs[15:8];
                r_acc += wd ? 2 : 1;
            end
            if (kd == OP_CMP || kd == OP_SCAN) begin
                lhs  = (kd == OP_SCAN) ? e_ax : s;
                e_zf = wd ? (lhs == d) : (lhs[7:0] == d[7:0]);
            end
            if (kd == OP_LOAD) begin
                if (wd) e_ax = s;
                else    e_ax[7:0] = s[7:0];
            end
            if (kd != OP_SCAN && kd != OP_STORE) e_si = e_si + stp;
            if (kd != OP_LOAD) e_di = e_di + stp;
            if (pf == 2'd0) break;
            e_cx = e_cx - 16'd1;
            if (e_cx == 16'd0) break;
            if ((kd == OP_CMP || kd == OP_SCAN) &&
                ((pf == 2'd2 && !e_zf) || (pf == 2'd3 && e_zf))) break;
        end
    endtask

    task automatic do_op(input logic [5:0] opc, input logic [15:0] s0, input logic [15:0] d0,
                         input logic [15:0] c0, input logic [15:0] dsv, input logic [15:0] esv,
                         input logic dfv, input logic [15:0] a0, input bit disturb);
        int n, acks0, mism;
        e_si = s0; e_di = d0; e_cx = c0; e_ds = dsv; e_es = esv; e_df = dfv; e_ax = a0;
        r_acc = 0;
        ref_exec(opc);
        @(negedge clk);
        acks0 = n_acks;
        opcode = opc; si_init = s0; di_init = d0; cx_init = c0;
        ds_init = dsv; es_init = esv; df_init = dfv; ax_init = a0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 0;
        while (!done && n < 5000) begin
            if (disturb && n == 2) begin
                opcode = {2'd1, 1'b1, OP_STORE}; si_init = ~s0; di_init = ~d0;
                cx_init = 16'd9; ax_init = ~a0; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        chk("R10 done reached", 32'(done), 32'd1);
        chk("R4 SI final", 32'(si), 32'(e_si));
        chk("R4 DI final", 32'(di), 32'(e_di));
        chk("R6 CX final", 32'(cx), 32'(e_cx));
        chk("R5 AX final", 32'(ax), 32'(e_ax));
        chk("R3 ZF final", 32'(zf), 32'(e_zf));
        chk("R9 byte accesses", 32'(n_acks - acks0), 32'(r_acc));
        mism = 0;
        foreach (rmem[k]) if (!mem.exists(k) || mem[k] !== rmem[k]) mism++;
        chk("R2 memory image", 32'(mism), 32'd0);
        @(negedge clk);
        chk("R10 idle after done", {30'd0, busy, done}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R10 watchdog actual=expired expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk("R11 reset outputs", {si, di, cx, ax, zf, busy, done, mem_req},
            {16'd0, 16'd0, 16'd0, 16'd0, 4'd0});
        rst_n = 1'b1;
        @(negedge clk);

        // REPNE byte compare, stops on third element (equal)
        mem.delete(); rmem.delete();
        put(phys(16'h5000, 16'h2500), 8'h42); put(phys(16'h5000, 16'h2501), 8'h45);
        put(phys(16'h5000, 16'h2502), 8'h34); put(phys(16'h5000, 16'h2503), 8'h23);
        put(phys(16'h6000, 16'h2500), 8'h98); put(phys(16'h6000, 16'h2501), 8'h34);
        put(phys(16'h6000, 16'h2502), 8'h34); put(phys(16'h6000, 16'h2503), 8'h23);
        do_op({2'd3, 1'b0, OP_CMP}, 16'h2500, 16'h2500, 16'd4, 16'h5000, 16'h6000, 1'b0, 16'h0, 1'b0);
        chk("R7 REPNE stop SI", 32'(si), 32'h2503);
        chk("R7 REPNE stop CX", 32'(cx), 32'd1);

        // zero count under repeat: no access
        mem.delete(); rmem.delete();
        fill(16'h1000, 16'h0100, 255); fill(16'h2000, 16'h0200, 255);
        do_op({2'd1, 1'b1, OP_MOVE}, 16'h0100, 16'h0200, 16'd0, 16'h1000, 16'h2000, 1'b0, 16'h1234, 1'b0);
        chk("R8 zero count SI kept", 32'(si), 32'h0100);

        // word store, downward, DI at top of offset range (wrap of high byte)
        mem.delete(); rmem.delete();
        fill(16'h1234, 16'hFFFF, 255);
        do_op({2'd0, 1'b1, OP_STORE}, 16'h0, 16'hFFFF, 16'd5, 16'h0, 16'h1234, 1'b1, 16'hBEEF, 1'b0);
        chk("R5 store high byte at wrapped offset", 32'(mem[phys(16'h1234, 16'h0000)]), 32'hBE);
        chk("R6 single mode CX kept", 32'(cx), 32'd5);

        // segment wrap of physical address
        mem.delete(); rmem.delete();
        fill(16'hFFFF, 16'h0020, 255);
        put(20'h00010, 8'h5A);
        do_op({2'd0, 1'b0, OP_LOAD}, 16'h0020, 16'h0, 16'd1, 16'hFFFF, 16'h0, 1'b0, 16'hAA00, 1'b0);
        chk("R1 segment wrap load", 32'(ax), 32'hAA5A);

        // REPE word compare ending on first mismatch
        mem.delete(); rmem.delete();
        for (int k = 0; k < 8; k++) begin
            put(phys(16'h0300, 16'(16'h40 + k)), 8'(k));
            put(phys(16'h0400, 16'(16'h80 + k)), (k == 5) ? 8'hFF : 8'(k));
        end
        do_op({2'd2, 1'b1, OP_CMP}, 16'h40, 16'h80, 16'd4, 16'h0300, 16'h0400, 1'b0, 16'h0, 1'b0);
        chk("R7 REPE mismatch CX", 32'(cx), 32'd1);

        // match on last counted element: exhaustion and match in one update
        mem.delete(); rmem.delete();
        for (int k = 0; k < 4; k++) begin
            put(phys(16'h0500, 16'(16'h10 - k)), 8'h11);
            put(phys(16'h0600, 16'(16'h20 - k)), (k >= 2) ? 8'h11 : 8'h22);
        end
        do_op({2'd3, 1'b1, OP_CMP}, 16'h0F, 16'h1F, 16'd2, 16'h0500, 16'h0600, 1'b1, 16'h0, 1'b0);
        chk("R7 last element match CX", {15'd0, zf, cx}, {15'd0, 1'b1, 16'd0});

        // scan byte with REPNE finds AL
        mem.delete(); rmem.delete();
        fill(16'h0700, 16'h0300, 3);
        do_op({2'd3, 1'b0, OP_SCAN}, 16'h0, 16'h0300, 16'd6, 16'h0, 16'h0700, 1'b0, 16'h0002, 1'b0);

        // start while busy is ignored
        mem.delete(); rmem.delete();
        fill(16'h0800, 16'h0010, 255); fill(16'h0900, 16'h0020, 255);
        do_op({2'd1, 1'b0, OP_MOVE}, 16'h0010, 16'h0020, 16'd3, 16'h0800, 16'h0900, 1'b0, 16'h4444, 1'b1);

        // random mix
        for (int it = 0; it < 60; it++) begin
            logic [2:0]  kd;
            logic [15:0] so, dof, sg1, sg2;
            kd  = 3'($urandom_range(0, 4));
            so  = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(16'hFFF8, 16'hFFFF)) : 16'($urandom);
            dof = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(0, 7)) : 16'($urandom);
            sg1 = 16'($urandom);
            sg2 = 16'($urandom);
            mem.delete(); rmem.delete();
            fill(sg1, so, (kd == OP_CMP || kd == OP_SCAN) ? 2 : 255);
            fill(sg2, dof, (kd == OP_CMP || kd == OP_SCAN) ? 2 : 255);
            do_op({2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), kd}, so, dof,
                  16'($urandom_range(0, 6)), sg1, sg2, 1'($urandom_range(0, 1)),
                  16'($urandom_range(0, 2)), 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule